// File: doc/BRIEF.md
# Dual-Window Activity Watchdog

This block checks that a processor is still running by watching one activity line. Software changes the level of that line from time to time. A rising level change and a falling level change both count as a service. If the line holds one level for too long, the block gives a single-cycle expiry strobe. The reset sequencer uses that strobe to start a reset pulse.

The block has two time windows. After every reset it arms a long window, so that firmware has time to boot. The first service in that window switches the timer to a shorter window, and the timer stays in the shorter window until the next reset. The reset sequencer drives a reset-active input. While that input is high, the counter stays cleared and the timer returns to the long window.

After an expiry the timer does nothing until reset-active has been seen high. A disable input stands for a floating activity pin. While it is high the block never expires.

Top module: `dual_window_watchdog`

## Requirements
- R1: After `rst_n` is released, with `in_reset` high, `expire` is low.
- R2: If no service arrives, `expire` goes high exactly START_TICKS clock edges after the first edge at which `in_reset` is sampled low.
- R3: The first service after a reset switches the timer to the short window. With no further service, `expire` rises on the (NORMAL_TICKS+3)th clock edge after the line changes. Two of those edges are synchroniser delay and one is edge detection.
- R4: A low-to-high change and a high-to-low change of `wd_line` are both services. Each one restarts the window. If the line toggles more often than once per short window, `expire` never rises.
- R5: A line held constantly high or constantly low still expires. The line level makes no difference to the timing.
- R6: While `in_reset` is high the counter stays at zero and `expire` stays low. When `in_reset` falls, the timer is back in the long window, even if it was in the short window before.
- R7: `expire` is high for exactly one cycle per timeout.
- R8: After an expiry the timer stays idle and does not strobe again until `in_reset` has been high. When `in_reset` then falls, a new long window starts.
- R9: While `wd_disable` is high, `expire` stays low. When `wd_disable` falls, the count restarts from zero in the long window.
- R10: A high pulse on `wd_line` one clock period wide is seen as two services, one for each change. The timeout is then measured from the falling change.
- R11: If a service and the end of a window land on the same clock edge, the service wins. No strobe is given and a fresh short window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference tick clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's own flops |
| in_reset | input | 1 | High while the system reset sequencer holds reset |
| wd_disable | input | 1 | High when the activity pin is detected as unconnected |
| wd_line | input | 1 | Asynchronous activity line from the processor |
| expire | output | 1 | One-cycle timeout strobe |

## Verification
A service and the end of a window can fall on the same clock edge. The bench makes this happen in the short window. It changes the line a second time exactly NORMAL_TICKS cycles after the first change. The detected edge of that second change then reaches the counter on the cycle the counter reaches its limit. The bench passes the case only if no strobe appears on that edge and the next strobe comes a full short window plus the synchroniser delay after the second change. If expiry won instead, a strobe would appear NORMAL_TICKS+3 cycles after the first change.

// File: rtl/dual_window_watchdog.sv
module dual_window_watchdog #(
  parameter int unsigned START_TICKS = 54000,
  parameter int unsigned NORMAL_TICKS = 1680,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_reset,
  input  logic wd_disable,
  input  logic wd_line,
  output logic expire
);

  localparam int unsigned MAX_TICKS = (START_TICKS > NORMAL_TICKS) ? START_TICKS : NORMAL_TICKS;
  localparam int unsigned CW = $clog2(MAX_TICKS + 1);
  localparam logic [CW-1:0] START_LIM = CW'(START_TICKS - 1);
  localparam logic [CW-1:0] NORMAL_LIM = CW'(NORMAL_TICKS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic line_prev;
  logic normal_q;
  logic idle_q;
  logic [CW-1:0] cnt;

  wire line_s = sync_q[SYNC_STAGES-1];
  wire svc = line_s ^ line_prev;
  wire [CW-1:0] limit = normal_q ? NORMAL_LIM : START_LIM;
  wire at_limit = (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '0;
      line_prev <= 1'b0;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], wd_line};
      line_prev <= line_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      normal_q <= 1'b0;
      idle_q   <= 1'b0;
      expire   <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (wd_disable) begin
        cnt      <= '0;
        normal_q <= 1'b0;
        idle_q   <= idle_q & ~in_reset;
      end else if (in_reset) begin
        cnt      <= '0;
        normal_q <= 1'b0;
        idle_q   <= 1'b0;
      end else if (idle_q) begin
        cnt <= '0;
      end else if (svc) begin
        cnt      <= '0;
        normal_q <= 1'b1;
      end else if (at_limit) begin
        cnt      <= '0;
        normal_q <= 1'b0;
        idle_q   <= 1'b1;
        expire   <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dwd_checker.sv
module dwd_checker #(
  parameter int unsigned CW = 8,
  parameter int unsigned LIMIT = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_reset,
  input logic          wd_disable,
  input logic          expire,
  input logic [CW-1:0] cnt
);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) expire |=> !expire); // R7
  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) $past(wd_disable) |-> !expire); // R9
  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n) $past(in_reset) |-> !expire); // R6
  AST_CNT_HELD_RESET: assert property (@(posedge clk) disable iff (!rst_n) $past(in_reset) |-> (cnt == '0)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) ({{(32-CW){1'b0}}, cnt} < LIMIT)); // R2

endmodule

bind dual_window_watchdog dwd_checker #(.CW(CW), .LIMIT(MAX_TICKS)) u_dwd_chk (
  .clk(clk), .rst_n(rst_n), .in_reset(in_reset), .wd_disable(wd_disable),
  .expire(expire), .cnt(cnt)
);

// File: tb/dual_window_watchdog_bench.sv
module dual_window_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int START = 400;
  localparam int NORM = 60;

  logic clk = 1'b0, rst_n = 1'b0, in_reset = 1'b1, wd_disable = 1'b0, wd_line = 1'b0;
  logic expire;
  int checks = 0, failures = 0;

  dual_window_watchdog #(.START_TICKS(START), .NORMAL_TICKS(NORM)) u_dual_window_watchdog (
    .clk(clk), .rst_n(rst_n), .in_reset(in_reset), .wd_disable(wd_disable),
    .wd_line(wd_line), .expire(expire)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_seq();
    @(negedge clk) in_reset = 1'b1;
    repeat (6) @(negedge clk);
    in_reset = 1'b0;
  endtask

  task automatic measure(input int max, output int n);
    n = 0;
    for (int i = 1; i <= max; i++) begin
      @(posedge clk); @(negedge clk);
      if (expire) begin n = i; break; end
    end
  endtask

  task automatic count_strobes(input int cycles, output int k);
    k = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); @(negedge clk);
      if (expire) k++;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(expire == 1'b0, "R1 reset state", expire, 0);
  endtask

  task automatic t_startup_low();
    int n;
    wd_line = 1'b0;
    reset_seq();
    measure(START + 20, n);
    check(n == START, "R2 long window, line low", n, START);
    @(negedge clk);
    check(expire == 1'b0, "R7 strobe one cycle", expire, 0);
  endtask

  task automatic t_idle_after_expiry();
    int k, n;
    count_strobes(2 * START, k);
    check(k == 0, "R8 idle after expiry", k, 0);
    reset_seq();
    measure(START + 20, n);
    check(n == START, "R8 long window after idle", n, START);
  endtask

  task automatic t_startup_high();
    int n;
    wd_line = 1'b1;
    reset_seq();
    measure(START + 20, n);
    check(n == START, "R5 long window, line high", n, START);
  endtask

  task automatic t_normal_fall();
    int n;
    reset_seq();
    repeat (10) @(negedge clk);
    wd_line = 1'b0;
    measure(START, n);
    check(n == NORM + 3, "R3 short window after falling change", n, NORM + 3);
  endtask

  task automatic t_normal_rise();
    int n;
    reset_seq();
    repeat (10) @(negedge clk);
    wd_line = 1'b1;
    measure(START, n);
    check(n == NORM + 3, "R4 rising change is a service", n, NORM + 3);
  endtask

  task automatic t_keepalive();
    int k, sum;
    sum = 0;
    reset_seq();
    for (int j = 0; j < 20; j++) begin
      wd_line = ~wd_line;
      count_strobes(NORM / 2, k);
      sum += k;
    end
    check(sum == 0, "R4 steady toggling keeps quiet", sum, 0);
  endtask

  task automatic t_reset_restarts();
    int k, n;
    reset_seq();
    repeat (10) @(negedge clk);
    wd_line = ~wd_line;
    repeat (20) @(negedge clk);
    in_reset = 1'b1;
    count_strobes(2 * START, k);
    check(k == 0, "R6 quiet while in reset", k, 0);
    in_reset = 1'b0;
    measure(START + 20, n);
    check(n == START, "R6 back to long window", n, START);
  endtask

  task automatic t_disable();
    int k, n;
    reset_seq();
    repeat (10) @(negedge clk);
    wd_line = ~wd_line;
    repeat (10) @(negedge clk);
    wd_disable = 1'b1;
    count_strobes(2 * START, k);
    check(k == 0, "R9 quiet while disabled", k, 0);
    wd_disable = 1'b0;
    measure(START + 20, n);
    check(n == START, "R9 restart in long window", n, START);
  endtask

  task automatic t_pulse();
    int n;
    wd_line = 1'b0;
    reset_seq();
    repeat (10) @(negedge clk);
    wd_line = 1'b1;
    @(negedge clk);
    wd_line = 1'b0;
    measure(START, n);
    check(n == NORM + 3, "R10 narrow pulse gives two services", n, NORM + 3);
  endtask

  task automatic t_collision();
    int n;
    reset_seq();
    repeat (10) @(negedge clk);
    wd_line = ~wd_line;
    repeat (NORM) @(negedge clk);
    check(expire == 1'b0, "R11 no strobe before collision", expire, 0);
    wd_line = ~wd_line;
    measure(START, n);
    check(n == NORM + 3, "R11 service beats expiry", n, NORM + 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run timeout actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_startup_low();
    t_idle_after_expiry();
    t_startup_high();
    t_normal_fall();
    t_normal_rise();
    t_keepalive();
    t_reset_restarts();
    t_disable();
    t_pulse();
    t_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule